// File: doc/BRIEF.md
# EEPROM programming controller

This block lets a processor bus reach a small byte-wide nonvolatile data store. It has four byte registers: a two-byte address, a data byte and a control byte. Through them software reads single bytes and programs single bytes. Programming can erase and write in one step, erase only, or write only. A page mode collects several bytes in a temporary buffer and commits them all in one programming operation.

A programming operation has to be armed first. A separate arm bit opens a short window, and a go strobe inside that window starts the operation. For the length of the operation the block holds a busy flag, and during that time every register write and every read strobe is ignored. Programming time is modelled with a cycle counter whose length depends on the mode. A level interrupt reports that the store is ready. The storage itself is a register array that resets to the erased value 0xFF.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After reset the four registers read 0x00, `busy` and `irq` are 0, and every stored byte reads back as 0xFF.
- R2: Registers are selected by `bus_sel`: 0 is address bits 7:0, 1 is address high (bit 0 is address bit 8, bits 7:1 always read 0), 2 is data, 3 is control. The address is 9 bits wide and covers bytes 0 to 511.
- R3: The control byte layout is: bit 0 read strobe (reads 0), bit 1 arm, bit 2 go (reads 1 while programming), bit 3 interrupt enable, bits 5:4 mode, bit 6 page mode, bit 7 busy (read-only).
- R4: A control write with bit 0 set while idle loads the data register with the stored byte at the current address. The value is readable in the following cycle.
- R5: Writing the arm bit sets it for ARM_WIN cycles, after which it clears itself. A go write starts programming only if it falls in one of the ARM_WIN cycles after the arm write. Otherwise it has no effect.
- R6: Mode 00 stores the data byte. Mode 01 stores 0xFF. Mode 10 stores the old byte ANDed with the data byte.
- R7: While programming, `busy` and control bits 7 and 2 read 1 for exactly ERASE_CYC+WRITE_CYC cycles (mode 00), ERASE_CYC cycles (mode 01) or WRITE_CYC cycles (mode 10).
- R8: While busy, writes to the address, data and control registers and read strobes are all ignored.
- R9: Writing 1 to the page bit sets it, and writing 0 does not clear it. In page mode, each data write while idle loads the buffer slot chosen by address bits 1:0 and marks that slot. Programming commits only the marked slots, into the 4-byte page that holds the current address. It then clears the page bit and all marks.
- R10: An armed go with mode 11 clears the page bit and all buffer marks at once. It does not set `busy` and it changes no stored byte.
- R11: `irq` is 1 exactly when the interrupt enable bit is 1 and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | Programming in progress |
| irq | output | 1 | Ready interrupt level |

## Verification
The bench builds the block with ERASE_CYC=6, WRITE_CYC=4, ARM_WIN=4, PAGE_W=2 and the full 9-bit address. These short programming times make it practical to count the exact busy length of every mode. They also leave room to issue several ignored register writes inside one busy window. The 4-cycle arm window lets the bench hit both its last accepted cycle and the first expired cycle. The 4-slot page is small enough to load partially, so slots that were never loaded can be seen to stay unchanged.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        PM_ATOMIC = 2'b00,
        PM_ERASE  = 2'b01,
        PM_WRITE  = 2'b10,
        PM_FLUSH  = 2'b11
    } prog_mode_e;

    typedef enum logic [1:0] {
        RS_ADDR_LO = 2'd0,
        RS_ADDR_HI = 2'd1,
        RS_DATA    = 2'd2,
        RS_CTRL    = 2'd3
    } reg_sel_e;

    localparam int CB_RD    = 0;
    localparam int CB_ARM   = 1;
    localparam int CB_GO    = 2;
    localparam int CB_IRQEN = 3;
    localparam int CB_MODE  = 4;
    localparam int CB_PAGE  = 6;
    localparam int CB_BUSY  = 7;

    typedef struct packed {
        logic       page;
        prog_mode_e mode;
        logic       irq_en;
    } ctrl_state_t;

    function automatic logic [7:0] apply_mode(prog_mode_e m, logic [7:0] old_b, logic [7:0] new_b);
        case (m)
            PM_ATOMIC: return new_b;
            PM_ERASE:  return 8'hFF;
            PM_WRITE:  return old_b & new_b;
            default:   return old_b;
        endcase
    endfunction

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= CW'(WIN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign active = (cnt_q != '0);

    // R5: an open window shrinks by one each cycle unless reloaded
    p_arm_decay_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
    import nvm_pkg::*;
#(
    parameter int ERASE_CYC = 40,
    parameter int WRITE_CYC = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  prog_mode_e mode,
    output logic       busy,
    output logic       done
);
    localparam int CNT_W = $clog2(ERASE_CYC + WRITE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dur;

    always_comb begin
        case (mode)
            PM_ATOMIC: dur = CNT_W'(ERASE_CYC + WRITE_CYC);
            PM_ERASE:  dur = CNT_W'(ERASE_CYC);
            default:   dur = CNT_W'(WRITE_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (start)       cnt_q <= dur;
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    // R8: a new operation is only launched from idle
    p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R7: busy holds until the final counted cycle
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    // R7: busy drops right after completion
    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
    parameter int PAGE_W = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [PAGE_W-1:0]             slot,
    input  logic [7:0]                    ld_byte,
    input  logic                          clear,
    output logic [(1<<PAGE_W)-1:0][7:0]   slot_data,
    output logic [(1<<PAGE_W)-1:0]        marks
);
    localparam int SLOTS = 1 << PAGE_W;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [7:0] b_q;
        logic       m_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                b_q <= '0;
                m_q <= 1'b0;
            end else if (clear) begin
                m_q <= 1'b0;
            end else if (load && slot == PAGE_W'(g)) begin
                b_q <= ld_byte;
                m_q <= 1'b1;
            end
        end
        assign slot_data[g] = b_q;
        assign marks[g]     = m_q;
    end

    // R9, R10: a clear leaves no slot marked
    p_clear_marks_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (marks == '0));

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 2,
    parameter int ERASE_CYC = 40,
    parameter int WRITE_CYC = 30,
    parameter int ARM_WIN   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       busy,
    output logic       irq
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - 8;

    logic [ADDR_W-1:0]       addr_q;
    logic [7:0]              data_q;
    ctrl_state_t             cs_q;
    logic [7:0]              mem [DEPTH];
    logic                    arm_active;
    logic                    done;
    logic [SLOTS-1:0][7:0]   slot_data;
    logic [SLOTS-1:0]        marks;

    logic       wr_addr_lo, wr_addr_hi, wr_data, wr_ctrl;
    logic       go_req, start, flush, rd_req;
    prog_mode_e mode_w;
    logic       unused_bits;

    assign wr_addr_lo = bus_we && !busy && (bus_sel == RS_ADDR_LO);
    assign wr_addr_hi = bus_we && !busy && (bus_sel == RS_ADDR_HI);
    assign wr_data    = bus_we && !busy && (bus_sel == RS_DATA);
    assign wr_ctrl    = bus_we && !busy && (bus_sel == RS_CTRL);
    assign mode_w     = prog_mode_e'(bus_wdata[CB_MODE+1:CB_MODE]);
    assign go_req     = wr_ctrl && bus_wdata[CB_GO] && arm_active;
    assign start      = go_req && (mode_w != PM_FLUSH);
    assign flush      = go_req && (mode_w == PM_FLUSH);
    assign rd_req     = wr_ctrl && bus_wdata[CB_RD];
    assign unused_bits = bus_wdata[CB_BUSY];

    nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
        .clk    (clk),
        .rst    (rst),
        .load   (wr_ctrl && bus_wdata[CB_ARM]),
        .active (arm_active)
    );

    nvm_prog_timer #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .mode  (mode_w),
        .busy  (busy),
        .done  (done)
    );

    nvm_page_buf #(.PAGE_W(PAGE_W)) u_page (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_data && cs_q.page),
        .slot      (addr_q[PAGE_W-1:0]),
        .ld_byte   (bus_wdata),
        .clear     (done || flush),
        .slot_data (slot_data),
        .marks     (marks)
    );

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            cs_q   <= '0;
        end else begin
            if (wr_addr_lo) addr_q[7:0]        <= bus_wdata;
            if (wr_addr_hi) addr_q[ADDR_W-1:8] <= bus_wdata[HI_W-1:0];
            if (wr_data)     data_q <= bus_wdata;
            else if (rd_req) data_q <= mem[addr_q];
            if (wr_ctrl) begin
                cs_q.irq_en <= bus_wdata[CB_IRQEN];
                cs_q.mode   <= mode_w;
            end
            if (done || flush)                     cs_q.page <= 1'b0;
            else if (wr_ctrl && bus_wdata[CB_PAGE]) cs_q.page <= 1'b1;
        end
    end

    // storage array, updated when an operation completes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done) begin
            if (cs_q.page) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (marks[s])
                        mem[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(s)}] <=
                            apply_mode(cs_q.mode, mem[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(s)}], slot_data[s]);
                end
            end else begin
                mem[addr_q] <= apply_mode(cs_q.mode, mem[addr_q], data_q);
            end
        end
    end

    always_comb begin
        case (bus_sel)
            RS_ADDR_LO: bus_rdata = addr_q[7:0];
            RS_ADDR_HI: bus_rdata = 8'(addr_q >> 8);
            RS_DATA:    bus_rdata = data_q;
            default:    bus_rdata = {busy, cs_q.page, cs_q.mode, cs_q.irq_en, busy, arm_active, 1'b0};
        endcase
    end

    assign irq = cs_q.irq_en && !busy;

    // R8: address and data stay frozen across a busy cycle
    p_addr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));
    p_data_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(data_q));
    // R5: programming only begins out of an open arm window
    p_start_armed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm_active));

endmodule

// File: tb/nvm_byte_ctrl_test.sv
`timescale 1ns/1ps
module nvm_byte_ctrl_test;

    localparam int EC = 6;
    localparam int WC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       busy, irq;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   fin = 1'b0;
    bit   ien = 1'b0;
    logic [7:0] model [512];

    always #2.5 clk = ~clk;

    nvm_byte_ctrl #(.ADDR_W(9), .PAGE_W(2), .ERASE_CYC(EC), .WRITE_CYC(WC), .ARM_WIN(4)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
    );

    function automatic logic [7:0] f_apply(logic [1:0] m, logic [7:0] o, logic [7:0] n);
        case (m)
            2'b00:   return n;
            2'b01:   return 8'hFF;
            2'b10:   return o & n;
            default: return o;
        endcase
    endfunction

    function automatic int f_dur(logic [1:0] m);
        case (m)
            2'b00:   return EC + WC;
            2'b01:   return EC;
            default: return WC;
        endcase
    endfunction

    function automatic logic [7:0] cb(bit rd, bit arm, bit go, logic [1:0] m, bit pg);
        return {1'b0, pg, m, ien, go, arm, rd};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        bus_sel = s; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(logic [1:0] s, output logic [7:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_addr(int a);
        wr(2'd0, a[7:0]);
        wr(2'd1, {7'd0, a[8]});
    endtask

    task automatic mem_read(int a, output logic [7:0] v);
        set_addr(a);
        wr(2'd3, cb(1, 0, 0, 2'b00, 0));
        peek(2'd2, v);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic arm_go(logic [1:0] m);
        wr(2'd3, cb(0, 1, 0, m, 0));
        wr(2'd3, cb(0, 0, 1, m, 0));
    endtask

    task automatic prog_byte(int a, logic [7:0] d, logic [1:0] m, string tag);
        int n;
        set_addr(a);
        wr(2'd2, d);
        arm_go(m);
        count_busy(n);
        chk({tag, " R7 busy length"}, n, f_dur(m));
        model[a] = f_apply(m, model[a], d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            chk("R1 register reset", v, 8'h00);
        end
        chk("R1 busy reset", busy, 1'b0);
        chk("R1 irq reset", irq, 1'b0);
        mem_read(300, v);
        chk("R1 R4 erased byte", v, 8'hFF);

        // R2 address width and high register
        wr(2'd1, 8'hFF);
        peek(2'd1, v);
        chk("R2 high byte reserved bits", v, 8'h01);
        wr(2'd0, 8'hFF);
        peek(2'd0, v);
        chk("R2 low byte", v, 8'hFF);

        // R3 R7 atomic program at top address with control readback
        wr(2'd2, 8'h5A);
        arm_go(2'b00);
        peek(2'd3, v);
        chk("R3 control while busy", v & 8'hFD, 8'h84);
        count_busy(n);
        chk("R7 atomic length", n, EC + WC);
        model[511] = 8'h5A;
        mem_read(511, v);
        chk("R6 atomic store", v, 8'h5A);

        // R6 write-only ANDs, erase restores FF
        prog_byte(511, 8'h0F, 2'b10, "write-only");
        mem_read(511, v);
        chk("R6 write-only AND", v, 8'h0A);
        prog_byte(511, 8'h00, 2'b01, "erase");
        mem_read(511, v);
        chk("R6 erase", v, 8'hFF);

        // R8 writes ignored during busy
        set_addr(10);
        wr(2'd2, 8'h33);
        arm_go(2'b01);
        wr(2'd0, 8'h77);
        wr(2'd2, 8'h99);
        wr(2'd3, {1'b0, 1'b1, 2'b10, 1'b1, 3'b001});
        count_busy(n);
        chk("R8 busy length with ignored writes", n + 3, EC);
        peek(2'd0, v);
        chk("R8 address unchanged", v, 8'd10);
        peek(2'd2, v);
        chk("R8 data unchanged", v, 8'h33);
        peek(2'd3, v);
        chk("R8 control unchanged", v & 8'hF8, 8'h10);
        model[10] = 8'hFF;

        // R5 go without arm is ignored
        set_addr(20);
        wr(2'd2, 8'h12);
        wr(2'd3, cb(0, 0, 1, 2'b00, 0));
        chk("R5 unarmed go ignored", busy, 1'b0);
        // R5 window expiry
        wr(2'd3, cb(0, 1, 0, 2'b00, 0));
        peek(2'd3, v);
        chk("R5 arm bit set", v[1], 1'b1);
        repeat (4) @(negedge clk);
        peek(2'd3, v);
        chk("R5 arm bit cleared", v[1], 1'b0);
        wr(2'd3, cb(0, 0, 1, 2'b00, 0));
        chk("R5 late go ignored", busy, 1'b0);
        mem_read(20, v);
        chk("R5 byte unchanged after late go", v, 8'hFF);
        // R5 last accepted cycle of the window
        set_addr(20);
        wr(2'd2, 8'h12);
        wr(2'd3, cb(0, 1, 0, 2'b00, 0));
        repeat (3) @(negedge clk);
        wr(2'd3, cb(0, 0, 1, 2'b00, 0));
        chk("R5 go in last window cycle", busy, 1'b1);
        count_busy(n);
        model[20] = 8'h12;
        mem_read(20, v);
        chk("R5 byte stored", v, 8'h12);

        // R11 interrupt level
        ien = 1'b1;
        wr(2'd3, cb(0, 0, 0, 2'b00, 0));
        chk("R11 irq when idle and enabled", irq, 1'b1);
        set_addr(21);
        wr(2'd2, 8'h44);
        arm_go(2'b10);
        chk("R11 irq low while busy", irq, 1'b0);
        count_busy(n);
        chk("R11 irq after completion", irq, 1'b1);
        model[21] = 8'h44;
        ien = 1'b0;
        wr(2'd3, cb(0, 0, 0, 2'b00, 0));
        chk("R11 irq disabled", irq, 1'b0);

        // R9 page mode, sticky bit, partial load
        wr(2'd3, cb(0, 0, 0, 2'b00, 1));
        wr(2'd3, cb(0, 0, 0, 2'b00, 0));
        peek(2'd3, v);
        chk("R9 page bit sticky", v[6], 1'b1);
        set_addr(8'h41); wr(2'd2, 8'hA1);
        set_addr(8'h43); wr(2'd2, 8'hA3);
        set_addr(8'h40);
        arm_go(2'b00);
        count_busy(n);
        chk("R9 page busy length", n, EC + WC);
        peek(2'd3, v);
        chk("R9 page bit cleared", v[6], 1'b0);
        model[8'h41] = 8'hA1; model[8'h43] = 8'hA3;
        for (int a = 8'h40; a < 8'h44; a++) begin
            mem_read(a, v);
            chk("R9 page commit", v, model[a]);
        end
        // R9 marks cleared: next page only loads slot 0
        wr(2'd3, cb(0, 0, 0, 2'b00, 1));
        set_addr(8'h44); wr(2'd2, 8'hB0);
        arm_go(2'b00);
        count_busy(n);
        model[8'h44] = 8'hB0;
        mem_read(8'h44, v);
        chk("R9 second page slot 0", v, 8'hB0);
        mem_read(8'h45, v);
        chk("R9 stale mark not reused", v, 8'hFF);

        // R10 flush
        wr(2'd3, cb(0, 0, 0, 2'b00, 1));
        set_addr(8'h4A); wr(2'd2, 8'h00);
        arm_go(2'b11);
        chk("R10 flush no busy", busy, 1'b0);
        peek(2'd3, v);
        chk("R10 page cleared", v[6], 1'b0);
        wr(2'd3, cb(0, 0, 0, 2'b00, 1));
        set_addr(8'h48);
        arm_go(2'b00);
        count_busy(n);
        mem_read(8'h4A, v);
        chk("R10 flushed slot not committed", v, 8'hFF);

        // random single-byte programming against the model
        for (int it = 0; it < 40; it++) begin
            int a;
            logic [7:0] d;
            logic [1:0] m;
            a = $urandom_range(511, 0);
            d = 8'($urandom);
            m = 2'($urandom_range(2, 0));
            prog_byte(a, d, m, "random R6");
            mem_read(a, v);
            chk("random R4 R6 readback", v, model[a]);
        end

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule